// File: doc/BRIEF.md
# Interrupter With Moderation Timer

This block is a single event interrupter for a host controller. An event ring producer pulses `event_post_i` each time it writes an event. The block records that work is waiting. It raises a one-cycle interrupt pulse only when four things are true: interrupts are enabled, an event is outstanding, the handler is not already marked busy, and a moderation countdown has run out. Each interrupt reloads the countdown from a programmed interval. This keeps interrupts from coming closer together than that interval. When no event is waiting, the interval can pass with no interrupt, so the real gap can be longer.

Software reaches three 32-bit registers through one write port and one combinational read port. The control register holds the pending and enable bits. The moderation register holds the interval in its low half and the live countdown in its high half. The dequeue register holds the ring read pointer, a segment hint and the handler-busy flag. Software acknowledges an interrupt by writing 1 to the pending bit. It then writes the dequeue register with bit 3 set, which clears the busy flag and tells the block the ring has been read up to the new pointer. A prescaler divides the clock into moderation ticks. At the default of 12 clocks per tick, a 48 MHz clock gives a 250 ns tick.

Top module: `ir_moderated_interrupter`

## Requirements
- R1: After reset, select 0 reads 0x00000000, select 1 reads 0x00000FA0 (interval 4000, countdown 0), and select 2 reads 0x00000000.
- R2: Register select 0 is control (bit 0 pending, bit 1 enable), 1 is moderation (bits 15:0 interval, bits 31:16 countdown), 2 is dequeue (bits 31:4 pointer, bit 3 busy, bits 2:0 hint), and 3 reads zero. A write to select 1 loads the interval and the countdown together.
- R3: The countdown drops by one every CLKS_PER_TICK clocks and holds at zero. With interval I and events kept waiting, the gap between two interrupt pulses lies in [(I-1)*CLKS_PER_TICK+2, I*CLKS_PER_TICK+1] clocks.
- R4: When the countdown is zero, enable is 1, an event is outstanding and busy is 0, the next clock edge sets pending and busy, pulses `irq_o` high for exactly one cycle, and reloads the countdown from the current interval (zero included).
- R5: An `event_post_i` pulse marks an event outstanding. Any write to select 2 clears that mark, unless a post comes in the same cycle, in which case the post wins. From a post, with the other conditions met, `irq_o` is high two cycles later.
- R6: With no event outstanding, no interrupt is raised, even when the countdown is zero.
- R7: While enable is 0, no interrupt is raised and outstanding events are kept. Setting enable then fires an interrupt on the second edge after the write.
- R8: While busy is 1, no further interrupt is raised.
- R9: Writing 1 to control bit 0 clears pending. Writing 0 to it leaves pending unchanged. Control bit 1 is written directly.
- R10: A write to select 2 loads the pointer and hint. It clears busy only if data bit 3 is 1, and leaves busy unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_post_i | input | 1 | One-cycle pulse per event written to the ring |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wsel_i | input | 2 | Register select for the write |
| reg_wdata_i | input | 32 | Write data |
| reg_rsel_i | input | 2 | Register select for the read |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Register writes take effect on the next edge. The bench reads them back at the following falling edge, and reads never straddle an edge. An interrupt caused by a post, an enable write or a busy clear, with the countdown already at zero, appears exactly two edges after the input is driven. A scoreboard entry therefore holds a window one cycle wide. An interrupt that waits on the countdown can occur anywhere in the window given by R3, and the tick phase is free-running. For that case the driver queues the whole window, measured from the reload or the counter write. The monitor fails any pulse that falls outside the window or arrives with nothing queued, and names the requirement that forbids it at that time.

// File: rtl/ir_pkg.sv
package ir_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_DEQ  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // bit positions decoded by software
  localparam int unsigned CTRL_PEND_BIT = 0;
  localparam int unsigned CTRL_EN_BIT   = 1;
  localparam int unsigned DEQ_BUSY_BIT  = 3;
  localparam int unsigned DEQ_HINT_W    = 3;
  localparam int unsigned DEQ_PTR_LSB   = 4;
  localparam int unsigned DEQ_PTR_W     = REG_W - DEQ_PTR_LSB;
  localparam int unsigned MOD_CNT_LSB   = REG_W / 2;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned CLKS_PER_TICK = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(CLKS_PER_TICK - 1);

  logic [PRE_W-1:0] pre_q;

  function automatic logic [PRE_W-1:0] pre_next(input logic [PRE_W-1:0] cur);
    return (cur == LAST) ? '0 : cur + PRE_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_next(pre_q);
  end

  assign tick_o = (pre_q == LAST);

  // R3
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
endmodule

// File: rtl/ir_mod_timer.sv
module ir_mod_timer #(
  parameter int unsigned IVAL_W     = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned IVAL_RESET = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sw_wr_i,
  input  logic [IVAL_W-1:0] sw_ival_i,
  input  logic [CNT_W-1:0]  sw_cnt_i,
  input  logic              reload_i,
  output logic [IVAL_W-1:0] ival_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              expired_o
);
  logic [IVAL_W-1:0] ival_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] cur,
                                                  input logic tk);
    return (tk && cur != '0) ? cur - CNT_W'(1) : cur;
  endfunction

  function automatic logic [CNT_W-1:0] reload_val(input logic [IVAL_W-1:0] iv);
    return CNT_W'(iv);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ival_q <= IVAL_W'(IVAL_RESET);
      cnt_q  <= '0;
    end else if (sw_wr_i) begin
      ival_q <= sw_ival_i;
      cnt_q  <= sw_cnt_i;
    end else if (reload_i) begin
      cnt_q  <= reload_val(ival_q);
    end else begin
      cnt_q  <= count_step(cnt_q, tick_i);
    end
  end

  assign ival_o    = ival_q;
  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == '0);

  // R3
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_wr_i || reload_i) |=> (cnt_q <= $past(cnt_q)));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i && !reload_i && tick_i && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/ir_ctrl.sv
module ir_ctrl
  import ir_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  event_post_i,
  input  logic                  expired_i,
  input  logic                  wr_i,
  input  reg_sel_e              wsel_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic                  pend_o,
  output logic                  en_o,
  output logic                  busy_o,
  output logic                  outst_o,
  output logic [DEQ_HINT_W-1:0] hint_o,
  output logic [DEQ_PTR_W-1:0]  ptr_o,
  output logic                  fire_o,
  output logic                  irq_o
);
  logic pend_q, en_q, busy_q, outst_q, irq_q;
  logic [DEQ_HINT_W-1:0] hint_q;
  logic [DEQ_PTR_W-1:0]  ptr_q;
  logic ctrl_wr, deq_wr, fire;

  function automatic logic may_fire(input logic exp, input logic en,
                                    input logic outst, input logic busy);
    return exp & en & outst & ~busy;
  endfunction

  assign ctrl_wr = wr_i && (wsel_i == SEL_CTRL);
  assign deq_wr  = wr_i && (wsel_i == SEL_DEQ);
  assign fire    = may_fire(expired_i, en_q, outst_q, busy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      outst_q <= 1'b0;
      irq_q   <= 1'b0;
      hint_q  <= '0;
      ptr_q   <= '0;
    end else begin
      outst_q <= event_post_i | (outst_q & ~deq_wr);
      irq_q   <= fire;
      if (fire)                                  pend_q <= 1'b1;
      else if (ctrl_wr && wdata_i[CTRL_PEND_BIT]) pend_q <= 1'b0;
      if (ctrl_wr) en_q <= wdata_i[CTRL_EN_BIT];
      if (fire)                                 busy_q <= 1'b1;
      else if (deq_wr && wdata_i[DEQ_BUSY_BIT]) busy_q <= 1'b0;
      if (deq_wr) begin
        ptr_q  <= wdata_i[REG_W-1:DEQ_PTR_LSB];
        hint_q <= wdata_i[DEQ_HINT_W-1:0];
      end
    end
  end

  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign busy_o  = busy_q;
  assign outst_o = outst_q;
  assign hint_o  = hint_q;
  assign ptr_o   = ptr_q;
  assign fire_o  = fire;
  assign irq_o   = irq_q;

  // R4
  fire_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (irq_q && pend_q && busy_q));
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R5
  post_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_post_i |=> outst_q);
endmodule

// File: rtl/ir_moderated_interrupter.sv
module ir_moderated_interrupter
  import ir_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 12,
  parameter int unsigned IVAL_W        = 16,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned IVAL_RESET    = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_post_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_wsel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic [1:0]       reg_rsel_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  reg_sel_e wsel, rsel;
  logic tick, expired, fire, mod_wr;
  logic pend, en, busy, outst;
  logic [IVAL_W-1:0]     ival;
  logic [CNT_W-1:0]      cnt;
  logic [DEQ_HINT_W-1:0] hint;
  logic [DEQ_PTR_W-1:0]  ptr;

  assign wsel   = reg_sel_e'(reg_wsel_i);
  assign rsel   = reg_sel_e'(reg_rsel_i);
  assign mod_wr = reg_wr_i && (wsel == SEL_MOD);

  ir_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick));

  ir_mod_timer #(.IVAL_W(IVAL_W), .CNT_W(CNT_W), .IVAL_RESET(IVAL_RESET)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sw_wr_i(mod_wr),
    .sw_ival_i(reg_wdata_i[IVAL_W-1:0]),
    .sw_cnt_i(reg_wdata_i[MOD_CNT_LSB +: CNT_W]),
    .reload_i(fire), .ival_o(ival), .cnt_o(cnt), .expired_o(expired));

  ir_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .event_post_i(event_post_i), .expired_i(expired),
    .wr_i(reg_wr_i), .wsel_i(wsel), .wdata_i(reg_wdata_i),
    .pend_o(pend), .en_o(en), .busy_o(busy), .outst_o(outst),
    .hint_o(hint), .ptr_o(ptr), .fire_o(fire), .irq_o(irq_o));

  function automatic logic [REG_W-1:0] mod_word(input logic [IVAL_W-1:0] iv,
                                                input logic [CNT_W-1:0] ct);
    logic [REG_W-1:0] w;
    w = '0;
    w[IVAL_W-1:0] = iv;
    w[MOD_CNT_LSB +: CNT_W] = ct;
    return w;
  endfunction

  always_comb begin
    reg_rdata_o = '0;
    case (rsel)
      SEL_CTRL: begin
        reg_rdata_o[CTRL_PEND_BIT] = pend;
        reg_rdata_o[CTRL_EN_BIT]   = en;
      end
      SEL_MOD:  reg_rdata_o = mod_word(ival, cnt);
      SEL_DEQ:  reg_rdata_o = {ptr, busy, hint};
      default:  reg_rdata_o = '0;
    endcase
  end

  // R6 R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(expired) && $past(en) && $past(outst)));
  // R8
  irq_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (busy && !$past(busy)));
endmodule

// File: tb/ir_moderated_interrupter_tb.sv
module ir_moderated_interrupter_tb;
  localparam int DIV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic event_post = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] wsel = '0;
  logic [31:0] wdata = '0;
  logic [1:0] rsel = '0;
  logic [31:0] rdata;
  logic irq;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  int last_irq = 0;
  string quiet_req = "R7";

  typedef struct { int lo; int hi; string req; } exp_t;
  exp_t q[$];
  exp_t mon_e;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ir_moderated_interrupter u_dut (
    .clk(clk), .rst_n(rst_n), .event_post_i(event_post), .reg_wr_i(reg_wr),
    .reg_wsel_i(wsel), .reg_wdata_i(wdata), .reg_rsel_i(rsel),
    .reg_rdata_o(rdata), .irq_o(irq));

  task automatic report_summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pop expectations as interrupts appear
  always @(negedge clk) begin
    if (rst_n && irq === 1'b1) begin
      irq_cnt++;
      last_irq = cyc;
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected irq actual=cycle %0d expected=none", quiet_req, cyc);
      end else begin
        mon_e = q.pop_front();
        if (cyc < mon_e.lo || cyc > mon_e.hi) begin
          failures++;
          $display("FAIL %s irq timing actual=%0d expected=[%0d,%0d]",
                   mon_e.req, cyc, mon_e.lo, mon_e.hi);
        end
      end
    end
  end

  task automatic push(input int lo, input int hi, input string req);
    exp_t e;
    e.lo = lo; e.hi = hi; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d,
                    input logic post, output int c);
    @(negedge clk);
    c = cyc;
    reg_wr = 1'b1; wsel = s; wdata = d; event_post = post;
    @(negedge clk);
    reg_wr = 1'b0; event_post = 1'b0;
  endtask

  task automatic post_evt(output int c);
    @(negedge clk);
    c = cyc;
    event_post = 1'b1;
    @(negedge clk);
    event_post = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    rsel = s;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    report_summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int c, r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, d); chk("R1", "ctrl reset", d, 32'h0);
    rd(2'd1, d); chk("R1", "moderation reset", d, 32'h0000_0FA0);
    rd(2'd2, d); chk("R1", "dequeue reset", d, 32'h0);

    // R7 event waits while disabled
    quiet_req = "R7";
    post_evt(c);
    idle(30);
    rd(2'd0, d); chk("R7", "pending stays clear while disabled", d, 32'h0);

    // R2 moderation write loads interval=3, countdown=0
    wr(2'd1, 32'h0000_0003, 1'b0, c);
    rd(2'd1, d); chk("R2", "moderation readback", d, 32'h0000_0003);

    // R7 enabling fires on the held event
    wr(2'd0, 32'h0000_0002, 1'b0, c);
    push(c + 2, c + 2, "R7");
    wait (irq_cnt >= 1);
    rd(2'd0, d); chk("R4", "pending and enable after irq", d, 32'h3);
    rd(2'd2, d); chk("R4", "busy set after irq", d, 32'h8);
    rd(2'd1, d); chk("R4", "countdown reloaded", d, 32'h0003_0003);

    // R8 busy blocks further interrupts; R3 countdown holds at zero
    quiet_req = "R8";
    idle(60);
    rd(2'd1, d); chk("R3", "countdown holds at zero", d, 32'h0000_0003);

    // R9 pending write-one-to-clear
    wr(2'd0, 32'h0000_0002, 1'b0, c);
    rd(2'd0, d); chk("R9", "zero write keeps pending", d, 32'h3);
    wr(2'd0, 32'h0000_0003, 1'b0, c);
    rd(2'd0, d); chk("R9", "one write clears pending", d, 32'h2);

    // R10 dequeue fields and busy clear
    wr(2'd2, 32'hABCD_0125, 1'b0, c);
    rd(2'd2, d); chk("R10", "busy kept, ptr and hint loaded", d, 32'hABCD_012D);
    quiet_req = "R6";
    wr(2'd2, 32'hABCD_0138, 1'b0, c);
    rd(2'd2, d); chk("R10", "busy cleared", d, 32'hABCD_0130);
    idle(40);   // R6 nothing outstanding after dequeue write (R5)
    rd(2'd0, d); chk("R6", "no pending without events", d, 32'h2);

    // R5 post fires two edges later with countdown zero
    post_evt(c);
    push(c + 2, c + 2, "R5");
    wait (irq_cnt >= 2);

    // R3 gap with interval 3; R5 post wins over dequeue write
    quiet_req = "R3";
    r = last_irq;
    wr(2'd0, 32'h0000_0003, 1'b0, c);
    wr(2'd2, 32'h0000_0008, 1'b1, c);
    push(r + 2 * DIV + 2, r + 3 * DIV + 1, "R3");
    wait (irq_cnt >= 3);

    // R2 countdown written directly to 2 with interval 2
    quiet_req = "R2";
    wr(2'd0, 32'h0000_0003, 1'b0, c);
    wr(2'd2, 32'h0000_0008, 1'b1, c);
    wr(2'd1, 32'h0002_0002, 1'b0, c);
    push(c + 1 + DIV + 2, c + 1 + 2 * DIV + 1, "R2");
    wait (irq_cnt >= 4);

    // R4 reload uses the new interval
    quiet_req = "R4";
    r = last_irq;
    wr(2'd2, 32'h0000_0008, 1'b1, c);
    push(r + DIV + 2, r + 2 * DIV + 1, "R4");
    wait (irq_cnt >= 5);

    // R4 interval zero: fires right after busy clears
    wr(2'd1, 32'h0000_0000, 1'b0, c);
    wr(2'd2, 32'h0000_0008, 1'b1, c);
    push(c + 2, c + 2, "R4");
    wait (irq_cnt >= 6);
    wr(2'd2, 32'h0000_0008, 1'b1, c);
    push(c + 2, c + 2, "R4");
    wait (irq_cnt >= 7);
    rd(2'd1, d); chk("R4", "zero reload", d, 32'h0);

    // R2 unused select
    rd(2'd3, d); chk("R2", "select 3 reads zero", d, 32'h0);

    // R6 quiet tail
    quiet_req = "R6";
    wr(2'd2, 32'h0000_0008, 1'b0, c);
    idle(30);
    chk("R6", "all expected interrupts seen", q.size(), 0);
    chk("R4", "interrupt count", irq_cnt, 7);

    report_summary();
    $finish;
  end
endmodule